// File: doc/BRIEF.md
# Byte-Wide Paged SRAM Bridge

This block connects a narrow host port to an external asynchronous byte-wide SRAM of 512K locations. The host has only three resources: an 8-bit data path, a 3-bit command field and one strobe line. Each rising edge of the strobe tells the bridge to run the command that is on the command field. The same data byte lanes carry address bytes, write data and read results.

The bridge holds a 19-bit address register. The host fills this register one byte at a time. Loading the middle byte also clears the top address bits. As a result, direct random access reaches only the lowest 64K. Locations above that are reached by streaming: every read or write can leave the address unchanged, step it up by one, or step it down by one after the access. The step wraps around the whole 512K space.

On the memory side the bridge drives the address, an active-low chip select, an active-low output enable and an active-low write strobe. It also drives separate output-enable signals that control the direction of the host bus pads and the SRAM data pads.

Top module: `sram_byte_bridge`

## Requirements
- R1: The command codes are: 000 load address low byte, 001 load address middle byte, 010 read, 011 read then step up, 100 read then step down, 101 write, 110 write then step up, 111 write then step down. The command and the byte on `host_din` are sampled once the strobe's rising edge has passed a two-stage synchronizer.
- R2: Each rising edge of `host_strobe` runs its command exactly once. Holding the strobe high for many cycles runs the command no further times.
- R3: Load-low replaces address bits [7:0] with the host byte and leaves bits [18:8] unchanged.
- R4: Load-middle replaces address bits [15:8] with the host byte, forces bits [18:16] to zero and keeps bits [7:0].
- R5: A read presents the SRAM byte at the current address on `host_dout` with `host_dout_en` high. The byte stays there until the next command is accepted.
- R6: A write stores the host byte at the current address in the SRAM.
- R7: The plain read and write commands leave the address unchanged. The step-up variants add one to the address after the access, and the step-down variants subtract one.
- R8: Stepping wraps modulo 2^19: up from 0x7FFFF gives 0x00000, and down from 0x00000 gives 0x7FFFF.
- R9: `host_dout_en` is high only from the end of a read until the next command is accepted. It is low after loads and writes.
- R10: `sram_we_n` is low only while `sram_ce_n` is low, `sram_oe_n` is high and `sram_dq_oe` is high. The address and write data do not change in the cycle where the write strobe falls. The SRAM data pads stay driven in the cycle where the write strobe rises.
- R11: After reset the address is zero, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are high, and both output enables are low.
- R12: `sram_oe_n` is low only while `sram_ce_n` is low and `sram_dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_strobe | input | 1 | Asynchronous execute strobe, active on its rising edge |
| host_cmd | input | 3 | Command code |
| host_din | input | 8 | Byte from the host: address byte or write data |
| host_dout | output | 8 | Read result toward the host |
| host_dout_en | output | 1 | Enables the host data pad drivers |
| sram_addr | output | 19 | SRAM address, equal to the address register |
| sram_ce_n | output | 1 | SRAM chip select, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write strobe, active low |
| sram_dq_in | input | 8 | Byte read from the SRAM data pads |
| sram_dq_out | output | 8 | Byte driven onto the SRAM data pads |
| sram_dq_oe | output | 1 | Enables the SRAM data pad drivers |

## Verification
A corrupted address register shows up directly on `sram_addr`. It is visible in the idle cycles right after the command that caused it, so every load and step is checked against the pins before the next strobe. A wrong step direction, a missed wrap, or a load-middle that fails to clear the top bits therefore shows up within one command. A write that lands at the wrong location, or a read taken from the wrong place, only becomes visible when a later read returns a byte that differs from the one written. For this reason the stimulus reads back every written byte, including bytes written above 64K and bytes at both ends of the address space. A sequencer fault that repeats a command on a long strobe, or that overlaps the write strobe with a read, shows up as an extra address step or as a pad-direction conflict in the same access.

// File: rtl/sbb_pkg.sv
// Shared definitions for the byte-wide SRAM bridge.
// Assumes the 3-bit command encoding that the host firmware uses.
package sbb_pkg;

    typedef enum logic [2:0] {
        CMD_LD_LO  = 3'b000,
        CMD_LD_MID = 3'b001,
        CMD_RD     = 3'b010,
        CMD_RD_UP  = 3'b011,
        CMD_RD_DN  = 3'b100,
        CMD_WR     = 3'b101,
        CMD_WR_UP  = 3'b110,
        CMD_WR_DN  = 3'b111
    } sbb_cmd_e;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_RD,
        SEQ_WR_SET,
        SEQ_WR_PULSE,
        SEQ_WR_HOLD
    } sbb_seq_e;

    function automatic logic cmd_is_read(input sbb_cmd_e c);
        return (c == CMD_RD) || (c == CMD_RD_UP) || (c == CMD_RD_DN);
    endfunction

    function automatic logic cmd_is_write(input sbb_cmd_e c);
        return (c == CMD_WR) || (c == CMD_WR_UP) || (c == CMD_WR_DN);
    endfunction

    function automatic logic cmd_steps(input sbb_cmd_e c);
        return (c == CMD_RD_UP) || (c == CMD_RD_DN) ||
               (c == CMD_WR_UP) || (c == CMD_WR_DN);
    endfunction

    function automatic logic cmd_steps_down(input sbb_cmd_e c);
        return (c == CMD_RD_DN) || (c == CMD_WR_DN);
    endfunction

endpackage

// File: rtl/sbb_strobe_sync.sv
// Synchronises the asynchronous host strobe into clk and finds its rising
// edge. On that edge it captures the command and data byte, which the host
// holds stable while the strobe is high, and issues a one-cycle valid pulse.
module sbb_strobe_sync
    import sbb_pkg::*;
#(
    parameter int DW     = 8,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_async,
    input  logic [2:0]    cmd_in,
    input  logic [DW-1:0] data_in,
    output logic          cmd_vld,
    output sbb_cmd_e      cmd_q,
    output logic [DW-1:0] data_q
);

    logic [STAGES:0] chain_q;
    logic            edge_det;

    // Synchroniser chain plus one history stage for edge detection.
    generate
        for (genvar g = 0; g <= STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= strobe_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign edge_det = chain_q[STAGES-1] & ~chain_q[STAGES];

    // Capture the command and byte on the detected edge and flag them as valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_vld <= 1'b0;
            cmd_q   <= CMD_LD_LO;
            data_q  <= '0;
        end else begin
            cmd_vld <= edge_det;
            if (edge_det) begin
                cmd_q  <= sbb_cmd_e'(cmd_in);
                data_q <= data_in;
            end
        end
    end

    // R2: one strobe edge never yields two consecutive pulses.
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_det |=> !edge_det);

endmodule

// File: rtl/sbb_addr_reg.sv
// Address register of the bridge. It takes byte loads (low byte, and the
// middle byte with the top bits cleared) and steps by one after an access,
// wrapping modulo 2^AW. It assumes at most one of load and step per cycle.
module sbb_addr_reg #(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_lo,
    input  logic          load_mid,
    input  logic [DW-1:0] load_byte,
    input  logic          step,
    input  logic          step_down,
    output logic [AW-1:0] addr_q
);

    localparam int MID_HI = 2 * DW - 1;

    logic [AW-1:0] addr_d;

    // Next address: load, step or hold.
    always_comb begin
        addr_d = addr_q;
        if (load_lo) begin
            addr_d[DW-1:0] = load_byte;
        end else if (load_mid) begin
            addr_d[MID_HI:DW] = load_byte;
            if (AW > 2 * DW) begin
                addr_d[AW-1:MID_HI+1] = '0;
            end
        end else if (step) begin
            addr_d = step_down ? addr_q - AW'(1) : addr_q + AW'(1);
        end
    end

    // Address storage with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    // R3: a low-byte load keeps every bit above the low byte.
    assert_low_load_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_lo |=> addr_q[AW-1:DW] == $past(addr_q[AW-1:DW]));

    // R4: a middle-byte load lands the byte and clears the top bits.
    assert_mid_load_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_mid && !load_lo) |=> (addr_q[MID_HI:DW] == $past(load_byte)) &&
                                   (addr_q[AW-1:MID_HI+1] == '0));

    // R7/R8: an upward step moves the address by exactly one, with wrap.
    assert_step_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !step_down && !load_lo && !load_mid) |=> addr_q == $past(addr_q) + AW'(1));

    // R7/R8: a downward step moves the address back by exactly one, with wrap.
    assert_step_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && step_down && !load_lo && !load_mid) |=> addr_q == $past(addr_q) - AW'(1));

endmodule

// File: rtl/sbb_access_seq.sv
// Access sequencer: decodes each accepted command, runs the SRAM read or
// write cycle with registered, glitch-free control outputs, and returns the
// read byte to the host. It assumes the host leaves enough time between
// strobes for a cycle to finish; a command arriving mid-cycle is dropped.
module sbb_access_seq
    import sbb_pkg::*;
#(
    parameter int DW      = 8,
    parameter int RD_WAIT = 2,
    parameter int WR_WAIT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_vld,
    input  sbb_cmd_e      cmd,
    input  logic [DW-1:0] cmd_byte,
    input  logic [DW-1:0] sram_dq_in,
    output logic          load_lo,
    output logic          load_mid,
    output logic          step,
    output logic          step_down,
    output logic          sram_ce_n,
    output logic          sram_oe_n,
    output logic          sram_we_n,
    output logic [DW-1:0] sram_dq_out,
    output logic          sram_dq_oe,
    output logic [DW-1:0] host_dout,
    output logic          host_dout_en
);

    localparam int MAXW = (RD_WAIT > WR_WAIT) ? RD_WAIT : WR_WAIT;
    localparam int CW   = (MAXW < 2) ? 1 : $clog2(MAXW);
    localparam logic [CW-1:0] RD_LAST = CW'(RD_WAIT - 1);
    localparam logic [CW-1:0] WR_LAST = CW'(WR_WAIT - 1);

    sbb_seq_e      state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    sbb_cmd_e      op_q;
    logic [DW-1:0] rdata_q;
    logic          accept, rd_done, wr_done;

    assign accept  = cmd_vld && (state_q == SEQ_IDLE);
    assign rd_done = (state_q == SEQ_RD) && (cnt_q == '0);
    assign wr_done = (state_q == SEQ_WR_HOLD);

    assign load_lo   = accept && (cmd == CMD_LD_LO);
    assign load_mid  = accept && (cmd == CMD_LD_MID);
    assign step      = (rd_done || wr_done) && cmd_steps(op_q);
    assign step_down = cmd_steps_down(op_q);

    // Next state and wait counter of the access cycle.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (accept && cmd_is_read(cmd)) begin
                    state_d = SEQ_RD;
                    cnt_d   = RD_LAST;
                end else if (accept && cmd_is_write(cmd)) begin
                    state_d = SEQ_WR_SET;
                end
            end
            SEQ_RD: begin
                if (cnt_q == '0) state_d = SEQ_IDLE;
                else             cnt_d   = cnt_q - CW'(1);
            end
            SEQ_WR_SET: begin
                state_d = SEQ_WR_PULSE;
                cnt_d   = WR_LAST;
            end
            SEQ_WR_PULSE: begin
                if (cnt_q == '0) state_d = SEQ_WR_HOLD;
                else             cnt_d   = cnt_q - CW'(1);
            end
            SEQ_WR_HOLD: state_d = SEQ_IDLE;
            default:     state_d = SEQ_IDLE;
        endcase
    end

    // State, counter and the registered SRAM controls that follow it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_IDLE;
            cnt_q      <= '0;
            sram_ce_n  <= 1'b1;
            sram_oe_n  <= 1'b1;
            sram_we_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            sram_ce_n  <= (state_d == SEQ_IDLE);
            sram_oe_n  <= (state_d != SEQ_RD);
            sram_we_n  <= (state_d != SEQ_WR_PULSE);
            sram_dq_oe <= (state_d == SEQ_WR_SET) || (state_d == SEQ_WR_PULSE) ||
                          (state_d == SEQ_WR_HOLD);
        end
    end

    // Latch the operation and the write byte of an accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q        <= CMD_LD_LO;
            sram_dq_out <= '0;
        end else if (accept) begin
            op_q        <= cmd;
            sram_dq_out <= cmd_byte;
        end
    end

    // Read result register and host pad enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q      <= '0;
            host_dout_en <= 1'b0;
        end else if (rd_done) begin
            rdata_q      <= sram_dq_in;
            host_dout_en <= 1'b1;
        end else if (accept) begin
            host_dout_en <= 1'b0;
        end
    end

    assign host_dout = rdata_q;

    // R10: the write strobe only falls into a selected, driven, non-reading cycle.
    assert_we_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce_n && sram_oe_n && sram_dq_oe));

    // R10: the data pads stay driven in the cycle where the write strobe ends.
    assert_we_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> sram_dq_oe);

    // R12: the SRAM only drives the bus while the bridge is not driving it.
    assert_oe_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_ce_n && !sram_dq_oe));

    // R9: the host pads are never driven during an SRAM access.
    assert_host_drive_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_dout_en |-> (sram_oe_n && sram_we_n && !sram_dq_oe));

endmodule

// File: rtl/sram_byte_bridge.sv
// Top of the byte-wide paged SRAM bridge: strobe synchroniser, access
// sequencer and address register. Pad tristates sit outside this block and
// are steered by host_dout_en and sram_dq_oe.
module sram_byte_bridge
    import sbb_pkg::*;
#(
    parameter int AW          = 19,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int RD_WAIT     = 2,
    parameter int WR_WAIT     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_strobe,
    input  logic [2:0]    host_cmd,
    input  logic [DW-1:0] host_din,
    output logic [DW-1:0] host_dout,
    output logic          host_dout_en,
    output logic [AW-1:0] sram_addr,
    output logic          sram_ce_n,
    output logic          sram_oe_n,
    output logic          sram_we_n,
    input  logic [DW-1:0] sram_dq_in,
    output logic [DW-1:0] sram_dq_out,
    output logic          sram_dq_oe
);

    logic          cmd_vld;
    sbb_cmd_e      cmd_q;
    logic [DW-1:0] byte_q;
    logic          load_lo, load_mid, step, step_down;

    sbb_strobe_sync #(.DW(DW), .STAGES(SYNC_STAGES)) sync_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_async (host_strobe),
        .cmd_in       (host_cmd),
        .data_in      (host_din),
        .cmd_vld      (cmd_vld),
        .cmd_q        (cmd_q),
        .data_q       (byte_q)
    );

    sbb_access_seq #(.DW(DW), .RD_WAIT(RD_WAIT), .WR_WAIT(WR_WAIT)) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_vld      (cmd_vld),
        .cmd          (cmd_q),
        .cmd_byte     (byte_q),
        .sram_dq_in   (sram_dq_in),
        .load_lo      (load_lo),
        .load_mid     (load_mid),
        .step         (step),
        .step_down    (step_down),
        .sram_ce_n    (sram_ce_n),
        .sram_oe_n    (sram_oe_n),
        .sram_we_n    (sram_we_n),
        .sram_dq_out  (sram_dq_out),
        .sram_dq_oe   (sram_dq_oe),
        .host_dout    (host_dout),
        .host_dout_en (host_dout_en)
    );

    sbb_addr_reg #(.AW(AW), .DW(DW)) addr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_lo   (load_lo),
        .load_mid  (load_mid),
        .load_byte (byte_q),
        .step      (step),
        .step_down (step_down),
        .addr_q    (sram_addr)
    );

    // R10: address and write data are settled when the write strobe falls.
    assert_we_setup_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> ($stable(sram_addr) && $stable(sram_dq_out)));

    // R11: the bridge never drives both ends of the data path at once.
    assert_pads_disjoint_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_dout_en && sram_dq_oe));

endmodule

// File: tb/sram_byte_bridge_tb.sv
// Bench for the SRAM bridge: a vector table walked by one loop, then directed
// checks for reset, top-bit clearing, wrap, upper-region streaming and a
// long strobe. The SRAM model is a small array indexed by a folded address.
module sram_byte_bridge_tb_top;

    localparam int AW = 19;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_strobe = 1'b0;
    logic [2:0]    host_cmd = 3'b000;
    logic [DW-1:0] host_din = '0;
    logic [DW-1:0] host_dout;
    logic          host_dout_en;
    logic [AW-1:0] sram_addr;
    logic          sram_ce_n, sram_oe_n, sram_we_n;
    logic [DW-1:0] sram_dq_in;
    logic [DW-1:0] sram_dq_out;
    logic          sram_dq_oe;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    sram_byte_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .host_strobe(host_strobe), .host_cmd(host_cmd),
        .host_din(host_din), .host_dout(host_dout), .host_dout_en(host_dout_en),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_dq_in(sram_dq_in), .sram_dq_out(sram_dq_out),
        .sram_dq_oe(sram_dq_oe)
    );

    // Behavioural SRAM: 4096 bytes, address folded so all used locations differ.
    logic [7:0] mem [0:4095];
    function automatic logic [11:0] fold(input logic [AW-1:0] a);
        return a[11:0] ^ {a[18:16], 9'b0};
    endfunction
    initial for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    always @(posedge clk) if (!sram_ce_n && !sram_we_n) mem[fold(sram_addr)] <= sram_dq_out;
    assign sram_dq_in = (!sram_ce_n && !sram_oe_n) ? mem[fold(sram_addr)] : 8'h00;

    typedef struct packed {
        logic [2:0]  cmd;
        logic [7:0]  din;
        logic [18:0] addr;
        logic [7:0]  rd;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{3'b000, 8'h34, 19'h00034, 8'h00},
        '{3'b001, 8'h12, 19'h01234, 8'h00},
        '{3'b110, 8'hA5, 19'h01235, 8'h00},
        '{3'b110, 8'h5A, 19'h01236, 8'h00},
        '{3'b000, 8'h34, 19'h01234, 8'h00},
        '{3'b011, 8'h00, 19'h01235, 8'hA5},
        '{3'b010, 8'h00, 19'h01235, 8'h5A},
        '{3'b100, 8'h00, 19'h01234, 8'h5A},
        '{3'b010, 8'h00, 19'h01234, 8'hA5},
        '{3'b111, 8'h77, 19'h01233, 8'h00},
        '{3'b101, 8'h3C, 19'h01233, 8'h00},
        '{3'b011, 8'h00, 19'h01234, 8'h3C},
        '{3'b010, 8'h00, 19'h01234, 8'h77},
        '{3'b001, 8'hFF, 19'h0FF34, 8'h00}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One host command: set command and byte, raise the strobe, then let it settle.
    task automatic issue(input logic [2:0] c, input logic [7:0] d, input int hold);
        @(negedge clk);
        host_cmd = c;
        host_din = d;
        @(negedge clk);
        host_strobe = 1'b1;
        repeat (hold) @(negedge clk);
        host_strobe = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic expect_read(input string req, input logic [7:0] d, input logic [18:0] a);
        check(req, "host_dout", int'(host_dout), int'(d));
        check(req, "host_dout_en", int'(host_dout_en), 1);
        check(req, "sram_addr", int'(sram_addr), int'(a));
    endtask

    task automatic expect_quiet(input string req, input logic [18:0] a);
        check(req, "sram_addr", int'(sram_addr), int'(a));
        check("R9", "host_dout_en", int'(host_dout_en), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state at the pins.
        check("R11", "sram_addr", int'(sram_addr), 0);
        check("R11", "sram_ce_n", int'(sram_ce_n), 1);
        check("R11", "sram_oe_n", int'(sram_oe_n), 1);
        check("R11", "sram_we_n", int'(sram_we_n), 1);
        check("R11", "sram_dq_oe", int'(sram_dq_oe), 0);
        check("R11", "host_dout_en", int'(host_dout_en), 0);

        // R1 R3 R4 R5 R6 R7: table walk.
        for (int i = 0; i < NV; i++) begin
            logic is_rd;
            is_rd = (VECS[i].cmd == 3'b010) || (VECS[i].cmd == 3'b011) ||
                    (VECS[i].cmd == 3'b100);
            issue(VECS[i].cmd, VECS[i].din, 4);
            check("R1", "table sram_addr", int'(sram_addr), int'(VECS[i].addr));
            check("R9", "table host_dout_en", int'(host_dout_en), int'(is_rd));
            if (is_rd) check("R5", "table host_dout", int'(host_dout), int'(VECS[i].rd));
        end

        // R3: low load keeps the middle byte.
        issue(3'b000, 8'hFF, 4);  expect_quiet("R3", 19'h0FFFF);
        // R7: streaming writes cross into the upper region.
        issue(3'b110, 8'h11, 4);  expect_quiet("R7", 19'h10000);
        issue(3'b110, 8'h22, 4);  expect_quiet("R7", 19'h10001);
        // R4: middle load clears the top bits.
        issue(3'b001, 8'h00, 4);  expect_quiet("R4", 19'h00001);
        issue(3'b000, 8'h00, 4);  expect_quiet("R3", 19'h00000);
        // R8: step down from zero wraps to the top.
        issue(3'b100, 8'h00, 4);  expect_read("R8", 8'h00, 19'h7FFFF);
        // R6: write at the top location.
        issue(3'b101, 8'h99, 4);  expect_quiet("R6", 19'h7FFFF);
        // R8: step up from the top wraps to zero.
        issue(3'b011, 8'h00, 4);  expect_read("R8", 8'h99, 19'h00000);
        // R6 R7: read back the bytes streamed above 64K.
        issue(3'b001, 8'hFF, 4);
        issue(3'b000, 8'hFF, 4);  expect_quiet("R4", 19'h0FFFF);
        issue(3'b011, 8'h00, 4);  expect_read("R6", 8'h11, 19'h10000);
        issue(3'b010, 8'h00, 4);  expect_read("R6", 8'h22, 19'h10000);
        // R2: a long strobe steps only once.
        issue(3'b011, 8'h00, 40); expect_read("R2", 8'h22, 19'h10001);
        // R3 R9: a load after a read keeps the top bits and releases the host pads.
        issue(3'b000, 8'h55, 4);  expect_quiet("R3", 19'h10055);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule